// File: doc/BRIEF.md
# Console UART Register Shim

This block gives a CPU bus a small byte-wide register window onto a simple console character channel. A single-cycle bus access (chip select, write enable, address, write byte) is masked down to a register offset. The offset selects one of five locations: the data register, the status register, a write-only control/pointer register, an interrupt-enable location and a modem-control location. Received characters come in on a valid/ready byte stream and are held one at a time in a lookahead slot. Transmitted characters leave on a second valid/ready byte stream.

The status read has state. Normally it reports a fixed line-status pattern plus a "character waiting" bit. Writing the value 3 to the control register arms a one-shot interrupt-pending report on the next status read, and that read disarms it. Writing 0x28 to the control register acknowledges the transmit interrupt.

Back-pressure rules:
- Receive side: `rx_ready` is raised only during a status read that finds the lookahead slot empty. A byte moves only when `rx_valid` and `rx_ready` are both high. A source that holds `rx_valid` simply waits for the next status read.
- Transmit side: `tx_valid` is high only during the cycle of a data-register write, and nothing is buffered. If `tx_ready` is low in that cycle, the byte is lost.

Top module: `console_reg_shim`

## Requirements
- R1: The register offset is the bus address ANDed with parameter `ADDR_MASK` (default 0x0F), so the address bits above the mask alias onto the same registers. The offsets are: data 0x8, interrupt enable 0x9, control 0xB, modem control 0xC, status 0xD.
- R2: A write to the data offset drives `tx_valid` high, with `tx_data` equal to the written byte, in the same cycle. If `tx_ready` is high in that cycle, `tx_irq` is high from the following cycle on.
- R3: A data write while `tx_ready` is low is dropped and leaves `tx_irq` unchanged. It also sets the sticky flag `err_tx_drop`.
- R4: A status read with no armed pointer returns 0x64. Bit 0 is also set when a received character is pending, meaning the slot is full or is filled by this same read.
- R5: A status read that finds the slot empty raises `rx_ready` in that cycle. If `rx_valid` is high, the byte is stored and `rx_pending` is high from the next cycle on. With the slot full, `rx_ready` stays low.
- R6: A data read returns the slot contents and empties the slot. On an empty slot it returns 0x00 and sets the sticky flag `err_rd_empty`.
- R7: After a control write of 0x03, the next status read returns 0x10 if `tx_irq` is set, else 0x20 if a received character is pending, else 0x00. That read returns the pointer to 0, so the status read after it is normal again.
- R8: A control write of 0x28 clears `tx_irq`. If `tx_irq` was already clear, it sets the sticky flag `err_bad_ack`.
- R9: Reads of the interrupt-enable offset and of every unlisted offset return 0x00. The following change no state: writes to the interrupt-enable offset, writes to the modem-control offset, and control writes of 0x00, 0x01 or 0x12.
- R10: Read data appears on `rdata` in the cycle after the read access. It holds its value until the next read.
- R11: A synchronous active-high `rst` clears the pointer, the lookahead slot, `tx_irq`, the three error flags and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus chip select, one access per cycle |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | ADDR_W | Bus address, masked by ADDR_MASK |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Console input byte available |
| rx_data | input | 8 | Console input byte |
| rx_ready | output | 1 | Shim takes the console input byte |
| tx_valid | output | 1 | Byte offered to console output |
| tx_data | output | 8 | Byte offered to console output |
| tx_ready | input | 1 | Console output accepts the byte |
| tx_irq | output | 1 | Transmit interrupt pending |
| rx_pending | output | 1 | Lookahead slot holds a character |
| err_rd_empty | output | 1 | Sticky: data read on empty slot |
| err_tx_drop | output | 1 | Sticky: data write dropped by back-pressure |
| err_bad_ack | output | 1 | Sticky: transmit acknowledge with none pending |

## Verification
The hardest case to reach is the armed pointer meeting a status read that also pulls a fresh character while a transmit interrupt is or is not pending. That single read decides between the 0x10 report, the 0x20 report and the plain pattern, and it also changes the slot. Directed sequences build each such state explicitly. Constrained random traffic then mixes control writes of 0x03 and 0x28 with random `rx_valid` and `tx_ready` and with aliased addresses, so armed reads land on every combination of slot and interrupt state.

// File: rtl/shim_pkg.sv
package shim_pkg;
  localparam logic [3:0] OFF_DATA = 4'h8;
  localparam logic [3:0] OFF_IEN  = 4'h9;
  localparam logic [3:0] OFF_CTRL = 4'hB;
  localparam logic [3:0] OFF_MCTL = 4'hC;
  localparam logic [3:0] OFF_STAT = 4'hD;

  localparam logic [7:0] CMD_ARM_PEND = 8'h03;
  localparam logic [7:0] CMD_TX_ACK   = 8'h28;

  localparam logic [7:0] STAT_BASE    = 8'h64;
  localparam logic [7:0] STAT_RX_BIT  = 8'h01;
  localparam logic [7:0] PEND_TX_CODE = 8'h10;
  localparam logic [7:0] PEND_RX_CODE = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_IEN,
    SEL_CTRL,
    SEL_MCTL,
    SEL_STAT,
    SEL_OTHER
  } reg_sel_e;
endpackage

// File: rtl/shim_decode.sv
module shim_decode import shim_pkg::*; #(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 'h0F
) (
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr & ADDR_MASK;
    sel    = SEL_NONE;
    if (cs) begin
      if      (offset == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
      else if (offset == ADDR_W'(OFF_IEN))  sel = SEL_IEN;
      else if (offset == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
      else if (offset == ADDR_W'(OFF_MCTL)) sel = SEL_MCTL;
      else if (offset == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
      else                                  sel = SEL_OTHER;
    end
  end
endmodule

// File: rtl/shim_rx_slot.sv
module shim_rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pull_req,
  input  logic              take,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              captured,
  output logic              err_empty
);
  assign rx_ready = pull_req & ~full;
  assign captured = rx_ready & rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 1'b0;
      data      <= '0;
      err_empty <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
      if (!full) err_empty <= 1'b1;
    end else if (captured) begin
      full <= 1'b1;
      data <= rx_data;
    end
  end

  assert_capture_stores_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !take) |=> (full && data == $past(rx_data)));

  assert_no_pull_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> (full && $stable(data)) || $past(take));

  assert_take_empties_R6: assert property (@(posedge clk) disable iff (rst)
    take |=> !full);

  assert_empty_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_empty |=> err_empty);
endmodule

// File: rtl/shim_irq_ctrl.sv
module shim_irq_ctrl import shim_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              tx_wr,
  input  logic              tx_ready,
  output logic              pend_mode,
  output logic              tx_irq,
  output logic              err_drop,
  output logic              err_ack
);
  logic [DATA_W-1:0] ptr_q;
  logic              tx_fire;
  logic              ack_cmd;

  assign pend_mode = (ptr_q == DATA_W'(CMD_ARM_PEND));
  assign tx_fire   = tx_wr & tx_ready;
  assign ack_cmd   = ctrl_wr & (wdata == DATA_W'(CMD_TX_ACK));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ctrl_wr) begin
      ptr_q <= wdata;
    end else if (stat_rd && pend_mode) begin
      ptr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq   <= 1'b0;
      err_drop <= 1'b0;
      err_ack  <= 1'b0;
    end else begin
      if (tx_fire) begin
        tx_irq <= 1'b1;
      end else if (ack_cmd) begin
        if (tx_irq) tx_irq  <= 1'b0;
        else        err_ack <= 1'b1;
      end
      if (tx_wr && !tx_ready) err_drop <= 1'b1;
    end
  end

  assert_irq_after_send_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && tx_ready) |=> tx_irq);

  assert_drop_keeps_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !tx_ready) |=> (err_drop && tx_irq == $past(tx_irq)));

  assert_ptr_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && pend_mode && !ctrl_wr) |=> !pend_mode);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata == DATA_W'(CMD_TX_ACK) && !tx_wr) |=> !tx_irq);

  assert_bad_ack_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata == DATA_W'(CMD_TX_ACK) && !tx_irq) |=> err_ack);
endmodule

// File: rtl/console_reg_shim.sv
module console_reg_shim import shim_pkg::*; #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              tx_irq,
  output logic              rx_pending,
  output logic              err_rd_empty,
  output logic              err_tx_drop,
  output logic              err_bad_ack
);
  localparam int DATA_W = 8;

  reg_sel_e          sel;
  logic              rd_acc, wr_acc;
  logic              stat_rd, data_rd, data_wr, ctrl_wr;
  logic              slot_full, slot_captured, pend_mode;
  logic [DATA_W-1:0] slot_data;
  logic              rx_pend_now;
  logic [DATA_W-1:0] stat_val, rd_val;

  shim_decode #(.ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK)) u_decode (
    .cs  (cs),
    .addr(addr),
    .sel (sel)
  );

  assign rd_acc  = cs & ~we;
  assign wr_acc  = cs & we;
  assign stat_rd = rd_acc & (sel == SEL_STAT);
  assign data_rd = rd_acc & (sel == SEL_DATA);
  assign data_wr = wr_acc & (sel == SEL_DATA);
  assign ctrl_wr = wr_acc & (sel == SEL_CTRL);

  shim_rx_slot #(.DATA_W(DATA_W)) u_rx_slot (
    .clk      (clk),
    .rst      (rst),
    .pull_req (stat_rd),
    .take     (data_rd),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .full     (slot_full),
    .data     (slot_data),
    .captured (slot_captured),
    .err_empty(err_rd_empty)
  );

  shim_irq_ctrl #(.DATA_W(DATA_W)) u_irq_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .wdata    (wdata),
    .stat_rd  (stat_rd),
    .tx_wr    (data_wr),
    .tx_ready (tx_ready),
    .pend_mode(pend_mode),
    .tx_irq   (tx_irq),
    .err_drop (err_tx_drop),
    .err_ack  (err_bad_ack)
  );

  assign tx_valid    = data_wr;
  assign tx_data     = wdata;
  assign rx_pending  = slot_full;
  assign rx_pend_now = slot_full | slot_captured;

  always_comb begin
    if (pend_mode) begin
      if (tx_irq)           stat_val = PEND_TX_CODE;
      else if (rx_pend_now) stat_val = PEND_RX_CODE;
      else                  stat_val = '0;
    end else begin
      stat_val = STAT_BASE | (rx_pend_now ? STAT_RX_BIT : 8'h00);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_val = stat_val;
      SEL_DATA: rd_val = slot_full ? slot_data : '0;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_acc) rdata <= rd_val;
  end

  assert_idle_no_tx_R2: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !tx_valid && !rx_ready);

  assert_ien_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && sel == SEL_IEN) |=> rdata == 8'h00);

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(rdata));

  assert_normal_status_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !pend_mode) |=> (rdata & 8'hFE) == 8'h64);
endmodule

// File: tb/test_console_reg_shim.sv
`timescale 1ns/1ps
module test_console_reg_shim;
  logic       clk = 1'b0;
  logic       rst;
  logic       cs, we;
  logic [7:0] addr, wdata, rdata;
  logic       rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       tx_irq, rx_pending, err_rd_empty, err_tx_drop, err_bad_ack;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit       m_full, m_irq, m_uf, m_ov, m_ba;
  logic [7:0] m_slot, m_ptr, m_rdata;

  always #2.5 clk = ~clk;

  console_reg_shim i_console_reg_shim (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_irq(tx_irq), .rx_pending(rx_pending), .err_rd_empty(err_rd_empty),
    .err_tx_drop(err_tx_drop), .err_bad_ack(err_bad_ack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] ofs, input bit rxp);
    if (ofs == 4'hD) begin
      if (m_ptr == 8'h03) return m_irq ? 8'h10 : (rxp ? 8'h20 : 8'h00);
      return 8'h64 | (rxp ? 8'h01 : 8'h00);
    end
    if (ofs == 4'h8) return m_full ? m_slot : 8'h00;
    return 8'h00;
  endfunction

  task automatic check_flags(input string tag);
    chk({tag, " R2/R8 tx_irq"}, {7'd0, tx_irq}, {7'd0, m_irq});
    chk({tag, " R5 rx_pending"}, {7'd0, rx_pending}, {7'd0, m_full});
    chk({tag, " R6 err_rd_empty"}, {7'd0, err_rd_empty}, {7'd0, m_uf});
    chk({tag, " R3 err_tx_drop"}, {7'd0, err_tx_drop}, {7'd0, m_ov});
    chk({tag, " R8 err_bad_ack"}, {7'd0, err_bad_ack}, {7'd0, m_ba});
    chk({tag, " R10 rdata"}, rdata, m_rdata);
  endtask

  // called at a negative edge
  task automatic access(input bit c, input bit w, input logic [7:0] a, input logic [7:0] d,
                        input bit rv, input logic [7:0] rdv, input bit tr);
    logic [3:0] ofs;
    bit rd, wr, pull, rxp;
    cs = c; we = w; addr = a; wdata = d; rx_valid = rv; rx_data = rdv; tx_ready = tr;
    ofs  = a[3:0];   // R1: mask 0x0F
    rd   = c && !w;
    wr   = c && w;
    pull = rd && ofs == 4'hD && !m_full && rv;
    rxp  = m_full || pull;
    #1;
    chk("R2 tx_valid", {7'd0, tx_valid}, {7'd0, wr && ofs == 4'h8});
    if (wr && ofs == 4'h8) chk("R2 tx_data", tx_data, d);
    chk("R5 rx_ready", {7'd0, rx_ready}, {7'd0, rd && ofs == 4'hD && !m_full});
    if (rd) m_rdata = exp_read(ofs, rxp);
    if (rd && ofs == 4'h8) begin
      if (!m_full) m_uf = 1;
      m_full = 0;
    end
    if (pull) begin m_full = 1; m_slot = rdv; end
    if (rd && ofs == 4'hD && m_ptr == 8'h03) m_ptr = 8'h00;
    if (wr && ofs == 4'hB) begin
      m_ptr = d;
      if (d == 8'h28) begin
        if (m_irq) m_irq = 0; else m_ba = 1;
      end
    end
    if (wr && ofs == 4'h8) begin
      if (tr) m_irq = 1; else m_ov = 1;
    end
    @(negedge clk);
    check_flags("access");
    cs = 0; we = 0;
  endtask

  task automatic do_reset();
    rst = 1; cs = 0; we = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_full = 0; m_irq = 0; m_uf = 0; m_ov = 0; m_ba = 0;
    m_slot = 0; m_ptr = 0; m_rdata = 0;
    check_flags("R11 reset");
  endtask

  task automatic rd_expect(input string req, input logic [7:0] a, input logic [7:0] exp,
                           input bit rv = 0, input logic [7:0] rdv = 8'h00);
    access(1, 0, a, 8'h00, rv, rdv, 1);
    chk(req, rdata, exp);
  endtask

  initial begin
    cs = 0; we = 0; addr = 0; wdata = 0; rx_valid = 0; rx_data = 0; tx_ready = 1; rst = 1;
    @(negedge clk);
    do_reset();
    // normal status, nothing pending
    rd_expect("R4 idle status", 8'h0D, 8'h64);
    // armed pointer, nothing pending
    access(1, 1, 8'h0B, 8'h03, 0, 0, 1);
    rd_expect("R7 pend none", 8'h0D, 8'h00);
    rd_expect("R7 disarmed", 8'h0D, 8'h64);
    // transmit, aliased address (R1)
    access(1, 1, 8'hF8, 8'hA5, 0, 0, 1);
    chk("R2 irq set", {7'd0, tx_irq}, 8'h01);
    access(1, 1, 8'h0B, 8'h03, 0, 0, 1);
    rd_expect("R7 pend tx", 8'h3D, 8'h10, 1, 8'h5A);
    chk("R5 pulled during armed read", {7'd0, rx_pending}, 8'h01);
    // ack
    access(1, 1, 8'h0B, 8'h28, 0, 0, 1);
    chk("R8 ack clears", {7'd0, tx_irq}, 8'h00);
    access(1, 1, 8'h0B, 8'h03, 0, 0, 1);
    rd_expect("R7 pend rx", 8'h0D, 8'h20);
    rd_expect("R4 status rx waiting", 8'h0D, 8'h65, 1, 8'h77);
    rd_expect("R6 data read", 8'h08, 8'h5A);
    rd_expect("R6 empty read", 8'h18, 8'h00);
    chk("R6 empty flag", {7'd0, err_rd_empty}, 8'h01);
    access(1, 1, 8'h0B, 8'h28, 0, 0, 1);
    chk("R8 bad ack", {7'd0, err_bad_ack}, 8'h01);
    access(1, 1, 8'h08, 8'h11, 0, 0, 0);
    chk("R3 drop flag", {7'd0, err_tx_drop}, 8'h01);
    chk("R3 irq unchanged", {7'd0, tx_irq}, 8'h00);
    // no-effect writes, then state observed
    access(1, 1, 8'h09, 8'hFF, 0, 0, 1);
    access(1, 1, 8'h0C, 8'hFF, 0, 0, 1);
    access(1, 1, 8'h0B, 8'h12, 0, 0, 1);
    rd_expect("R9 ien read", 8'h09, 8'h00);
    rd_expect("R9 status normal after no-op writes", 8'h0D, 8'h65, 1, 8'h33);
    rd_expect("R9 unlisted read", 8'h0E, 8'h00);
    rd_expect("R9 slot intact", 8'h08, 8'h33);
    // random traffic
    void'($urandom(32'h1234));
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] hi, d;
      op = $urandom_range(0, 9);
      hi = 8'($urandom_range(0, 15)) << 4;
      d  = 8'($urandom);
      case (op)
        0: access(1, 1, hi | 8'h08, d, $urandom_range(0,1), d, $urandom_range(0,3) != 0);
        1, 2: access(1, 0, hi | 8'h08, 0, $urandom_range(0,1), d, 1);
        3, 4: access(1, 0, hi | 8'h0D, 0, $urandom_range(0,1), d, 1);
        5: begin
          logic [7:0] cv;
          case ($urandom_range(0, 5))
            0, 1: cv = 8'h03;
            2: cv = 8'h28;
            3: cv = 8'h00;
            4: cv = 8'h12;
            default: cv = d;
          endcase
          access(1, 1, hi | 8'h0B, cv, 0, 0, 1);
        end
        6: access(1, $urandom_range(0,1), hi | 8'h09, d, 1, d, 1);
        7: access(1, 1, hi | 8'h0C, d, 1, d, 1);
        8: access(1, $urandom_range(0,1), hi | 8'($urandom_range(0, 7)), d, 1, d, 0);
        default: access(0, 0, hi, d, 1, d, 1);
      endcase
      if (i == 2000) do_reset();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule